// File: doc/BRIEF.md
# Serial-loaded dual DAC register interface

This block is the digital front end of a two-channel 12-bit converter. A host drives three serial pins: a serial clock, a data line and an active-low frame strobe. While the strobe is low, each rising serial clock shifts one data bit into a 16-bit input word, most significant bit first. When the strobe returns high, the word is decoded. Its top bit chooses channel A or channel B, and its low twelve bits are written into that channel's code register. A shutdown control bit in the same word is captured at the same moment.

Every part of the block runs on a fast system clock. The three serial pins are brought in through two-flop synchronizers, and serial clock and strobe edges are found by comparing the synchronized level with its value one cycle earlier. Each channel code is available both as the stored two's-complement value and as offset binary, which is the same value with its top bit inverted. The shutdown flag only reports the captured bit: the shifting and the registers keep working while it is set.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After synchronous reset, both channel codes are 0x000, both offset-binary outputs are 0x800, the shutdown flag is 0, and the 16-bit input word is all zeros.
- R2: While the strobe is low, each rising serial clock shifts the data pin into bit 0 of the input word, and the older bits move one place toward bit 15. The first bit sent therefore ends up in bit 15 of a 16-bit frame.
- R3: On the strobe's low-to-high transition, a word with bit 15 = 0 copies bits 11..0 into channel A, and channel B keeps its value.
- R4: On the strobe's low-to-high transition, a word with bit 15 = 1 copies bits 11..0 into channel B, and channel A keeps its value.
- R5: Channel codes and the shutdown flag change only on a strobe low-to-high transition. They hold their values while a frame is still being shifted.
- R6: Rising serial clocks while the strobe is high do not change the input word. A frame that has no clock edges therefore reloads the previous word unchanged.
- R7: Bit 13 of the word is the shutdown bit (1 = shut down). It is copied to the shutdown flag at every strobe low-to-high transition, whichever channel the word selects. Loading continues normally while the flag is set.
- R8: The offset-binary output of each channel equals its code with bit 11 inverted.
- R9: If a frame carries more or fewer than 16 clock edges, the input word holds the last 16 bits shifted, including bits left from earlier frames. Address, shutdown and data are then read from their fixed positions. Bits 14 and 12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_dat | input | 1 | Serial data pin, asynchronous |
| ser_frm_n | input | 1 | Frame strobe pin, active low, asynchronous |
| code_a | output | 12 | Channel A code, two's complement |
| code_b | output | 12 | Channel B code, two's complement |
| obin_a | output | 12 | Channel A code, offset binary |
| obin_b | output | 12 | Channel B code, offset binary |
| pwr_down | output | 1 | Captured shutdown bit |

## Verification
A pin change reaches the synchronized level after two system clocks. The shift or load it causes is registered on the third clock, so the outputs reflect a strobe rise three cycles after the pin moves. The bench holds each serial level for four system clocks and waits six system clocks after raising the strobe before it compares outputs. It drives and samples on the falling system clock edge, away from the register edge. The mid-frame checks for R5 are made while the strobe is still low, at a point where no load can be pending.

// File: rtl/dac_if_pkg.sv
// Package: shared widths, field positions and types for the dual DAC
// serial interface. Assumes a 16-bit word with a 12-bit data field.
package dac_if_pkg;
    localparam int WORD_W   = 16;
    localparam int DATA_W   = 12;
    localparam int ADDR_POS = 15;
    localparam int SD_POS   = 13;
    localparam int N_CHAN   = 2;

    typedef logic [DATA_W-1:0] code_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dac_pin_sync.sv
// Module: multi-bit two-stage synchronizer for asynchronous pins.
// Assumes each bit is independent; RST_VAL gives each bit's idle level.
module dac_pin_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl_out
);
    logic [W-1:0] stage_q [STAGES];

    // Shift each pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign lvl_out = stage_q[STAGES-1];
endmodule

// File: rtl/dac_edge_det.sv
// Module: rising-edge detector on synchronized levels.
// Assumes the inputs are already in the clk domain.
module dac_edge_det #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    output logic [W-1:0] rise_out
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_in;
    end

    assign rise_out = lvl_in & ~prev_q;
endmodule

// File: rtl/dac_word_shifter.sv
// Module: 16-bit serial input word, MSB first, and its field split.
// Assumes shift_en is a single-cycle strobe already gated by the frame.
module dac_word_shifter
    import dac_if_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  shift_en,
    input  logic  bit_in,
    output logic  addr_bit,
    output logic  sd_bit,
    output code_t data_field
);
    word_t word_q;

    // Shift one data bit in at each qualified serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= {word_q[WORD_W-2:0], bit_in};
    end

    assign addr_bit   = word_q[ADDR_POS];
    assign sd_bit     = word_q[SD_POS];
    assign data_field = word_q[DATA_W-1:0];
endmodule

// File: rtl/dac_chan_bank.sv
// Module: channel code registers and shutdown flag, written on load.
// Assumes load is a single-cycle strobe; addr picks the target channel.
module dac_chan_bank
    import dac_if_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  addr,
    input  logic  sd_in,
    input  code_t data_in,
    output code_t codes [N_CHAN],
    output logic  sd_q
);
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        code_t code_q;

        // Write this channel when the frame addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 code_q <= '0;
            else if (load && (addr == c[0]))            code_q <= data_in;
        end

        assign codes[c] = code_q;
    end

    // Capture the shutdown bit at every load.
    always_ff @(posedge clk) begin
        if (!rst_n)    sd_q <= 1'b0;
        else if (load) sd_q <= sd_in;
    end
endmodule

// File: rtl/dual_dac_serial_if.sv
// Module: top of the dual DAC serial interface. It synchronizes the pins,
// detects edges, shifts frames and loads the channel registers.
// Assumes the system clock is several times faster than the serial clock.
module dual_dac_serial_if
    import dac_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_frm_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic [DATA_W-1:0] obin_a,
    output logic [DATA_W-1:0] obin_b,
    output logic              pwr_down
);
    logic [2:0] pin_lvl;
    logic [1:0] edge_rise;
    logic       sclk_rise, frm_rise, frm_lvl, shift_en;
    logic       addr_bit, sd_bit;
    code_t      data_field;
    code_t      codes [N_CHAN];
    code_t      obin  [N_CHAN];

    // Bit order {frame, data, clock}; the frame strobe idles high.
    dac_pin_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_in({ser_frm_n, ser_dat, ser_clk}),
        .lvl_out(pin_lvl)
    );

    assign frm_lvl = pin_lvl[2];

    dac_edge_det #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl_in({pin_lvl[2], pin_lvl[0]}),
        .rise_out(edge_rise)
    );

    assign sclk_rise = edge_rise[0];
    assign frm_rise  = edge_rise[1];
    assign shift_en  = sclk_rise & ~frm_lvl;

    dac_word_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_en(shift_en), .bit_in(pin_lvl[1]),
        .addr_bit(addr_bit), .sd_bit(sd_bit), .data_field(data_field)
    );

    dac_chan_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .load(frm_rise), .addr(addr_bit),
        .sd_in(sd_bit), .data_in(data_field),
        .codes(codes), .sd_q(pwr_down)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_obin
        assign obin[c] = {~codes[c][DATA_W-1], codes[c][DATA_W-2:0]};
    end

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign obin_a = obin[0];
    assign obin_b = obin[1];
endmodule

// File: rtl/dual_dac_serial_if_checks.sv
// Module: assertion checker bound to dual_dac_serial_if.
// Assumes it sees the top's ports and its internal frame signals.
module dual_dac_serial_if_checks
    import dac_if_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frm_lvl,
    input logic              frm_rise,
    input logic              addr_bit,
    input logic              sd_bit,
    input logic [DATA_W-1:0] data_field,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              pwr_down
);
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (code_a == '0 && code_b == '0 && !pwr_down));

    a_r5_hold_outside_load: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_rise |=> ($stable(code_a) && $stable(code_b) && $stable(pwr_down)));

    a_r6_word_frozen_frame_high: assert property (@(posedge clk) disable iff (!rst_n)
        frm_lvl |=> ($stable(addr_bit) && $stable(sd_bit) && $stable(data_field)));

    // R3 and R4: only one channel can change at any load.
    a_r3_single_channel_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(code_a) || $stable(code_b)));
endmodule

bind dual_dac_serial_if dual_dac_serial_if_checks u_checks (
    .clk(clk), .rst_n(rst_n),
    .frm_lvl(frm_lvl), .frm_rise(frm_rise),
    .addr_bit(addr_bit), .sd_bit(sd_bit), .data_field(data_field),
    .code_a(code_a), .code_b(code_b), .pwr_down(pwr_down)
);

// File: tb/dual_dac_serial_if_test.sv
module dual_dac_serial_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_frm_n = 1'b1;
    logic [11:0] code_a, code_b, obin_a, obin_b;
    logic        pwr_down;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mdl_word = '0;
    logic [11:0] exp_a = '0;
    logic [11:0] exp_b = '0;
    logic        exp_sd = 1'b0;

    always #5 clk = ~clk;

    dual_dac_serial_if uut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_frm_n(ser_frm_n),
        .code_a(code_a), .code_b(code_b),
        .obin_a(obin_a), .obin_b(obin_b), .pwr_down(pwr_down)
    );

    function automatic logic [11:0] to_obin(input logic [11:0] c);
        return {~c[11], c[10:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        check(req, {20'd0, code_a}, {20'd0, exp_a});
        check(req, {20'd0, code_b}, {20'd0, exp_b});
        check({req, "/R8"}, {20'd0, obin_a}, {20'd0, to_obin(exp_a)});
        check({req, "/R8"}, {20'd0, obin_b}, {20'd0, to_obin(exp_b)});
        check({req, "/R7"}, {31'd0, pwr_down}, {31'd0, exp_sd});
    endtask

    // Send n bits of bits_in MSB first (bit n-1 first), then raise the strobe.
    task automatic send_frame(input logic [31:0] bits_in, input int n, input string req);
        ser_frm_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits_in[i];
            ser_clk = 1'b0;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            mdl_word = {mdl_word[14:0], bits_in[i]};
            if (i == n / 2) begin
                wait_clk(3);
                check_all("R5 mid-frame hold");
            end
        end
        ser_clk = 1'b0;
        wait_clk(4);
        ser_frm_n = 1'b1;
        if (mdl_word[15]) exp_b = mdl_word[11:0];
        else              exp_a = mdl_word[11:0];
        exp_sd = mdl_word[13];
        wait_clk(6);
        check_all(req);
    endtask

    // Clock edges with random data while the strobe stays high.
    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = 1'($urandom);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
            wait_clk(4);
        end
    endtask

    initial begin
        void'($urandom(32'd24680));
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state.
        check_all("R1 reset");

        // R2/R3: directed frame to channel A with positive full scale.
        send_frame({16'h0, 16'h07FF}, 16, "R2/R3 chan A 0x7FF");
        // R4: channel B, negative full scale; A must hold.
        send_frame({16'h0, 16'h8800}, 16, "R4 chan B 0x800");
        // R3: channel A one LSB below zero.
        send_frame({16'h0, 16'h0FFF}, 16, "R3 chan A 0xFFF");
        // R7: shutdown set via channel B frame, bits 14 and 12 set (R9 ignored).
        send_frame({16'h0, 16'hF123}, 16, "R7 shutdown set, R9 bits 14/12");
        // R7: registers still load while shut down; frame to A clears shutdown? no: keep set.
        send_frame({16'h0, 16'h2456}, 16, "R7 load during shutdown");
        send_frame({16'h0, 16'h0000}, 16, "R7 shutdown clear, R3 zero");

        // R6: clocks with strobe high, then an empty frame reloads the old word.
        idle_clocks(10);
        send_frame(32'h0, 0, "R6 clocks while strobe high ignored");

        // R9: long and short frames.
        send_frame({12'h0, 20'hABCDE}, 20, "R9 20-bit frame");
        send_frame({20'h0, 12'h3C5}, 12, "R9 12-bit frame");

        // Random frames with lengths 12..20.
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            int n;
            w = $urandom;
            n = 12 + int'($urandom % 9);
            if (k % 7 == 3) idle_clocks(3);
            send_frame(w, n, (n == 16) ? "R2 random frame" : "R9 random frame");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule